// File: doc/BRIEF.md
# Source Address Decoder to Node

The decoder turns a physical address issued by a requester into a system address. A system address is a destination node identifier together with an offset that is local to that node. Software-visible programming is out of scope. A configuration write port loads two small range tables, one for the memory space and one for the I/O space.

Each table entry holds a valid bit, an inclusive base, an inclusive limit and a 3-bit target node. A lookup carries a space select and an address, and only the table for that space is searched. When several valid entries cover the address, the lowest-numbered entry is used. The reply carries a hit flag and the node. It also carries the address minus the entry base, so every target sees its window start at zero.

If no entry matches, the reply raises a miss flag with node 0 and offset 0. Every reply is registered and appears one clock after the request.

Top module: `src_addr_decoder`

## Requirements
- R1: A lookup whose address lies inside a valid entry of the selected table returns rsp_hit=1, rsp_miss=0 and that entry's node on rsp_node.
- R2: On a hit, rsp_offset equals the request address minus the matching entry's base (rebased to the target's local zero).
- R3: Bounds are inclusive. An address equal to the base or to the limit hits. An address one below the base or one above the limit does not match that entry.
- R4: Memory requests (req_io=0) search only the memory table and I/O requests (req_io=1) search only the I/O table. An entry in one table never answers a request for the other space.
- R5: When more than one valid entry covers the address, the entry with the lowest index supplies the node and base.
- R6: A request that matches no valid entry returns rsp_miss=1, rsp_hit=0, rsp_node=0 and rsp_offset=0. On any valid reply, exactly one of rsp_hit and rsp_miss is set.
- R7: The reply is registered. rsp_valid and the result appear on the clock edge after the request. With req_valid=0, the next cycle shows rsp_valid=0, rsp_hit=0, rsp_miss=0, rsp_node=0 and rsp_offset=0.
- R8: Reset clears every entry of both tables to invalid and clears all reply outputs to 0. A lookup straight after reset misses.
- R9: A configuration write selects the table with cfg_io (0 memory, 1 I/O) and the entry with cfg_idx. It takes effect for lookups presented from the next cycle onward. Writing cfg_valid=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_io | input | 1 | Table select for the write: 0 memory, 1 I/O |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_base | input | ADDR_W | Inclusive lower bound to store |
| cfg_limit | input | ADDR_W | Inclusive upper bound to store |
| cfg_node | input | NODE_W | Target node to store |
| req_valid | input | 1 | Lookup request present |
| req_io | input | 1 | Space of the lookup: 0 memory, 1 I/O |
| req_addr | input | ADDR_W | Physical address to decode |
| rsp_valid | output | 1 | Reply present (one cycle after req_valid) |
| rsp_hit | output | 1 | Address matched an entry |
| rsp_miss | output | 1 | Address matched no entry |
| rsp_node | output | NODE_W | Destination node, 0 on a miss |
| rsp_offset | output | ADDR_W | Address rebased to the node's local zero, 0 on a miss |

## Verification
The memory table is loaded with two adjacent windows and a third window that overlaps the upper one. The I/O table is loaded with two adjacent windows. Lookups then probe both sides of every boundary, including the last address of a window and the first of the next. This separates an inclusive compare from an off-by-one, and a node that is correct from an offset that is wrongly rebased.

Addresses inside the overlap tell lowest-index priority apart from last-match priority. Each space is also probed with addresses that only the other space maps, which exposes leakage between the tables. Directed sequences cover the empty table after reset, idle cycles and the one-cycle reply timing. They also invalidate an entry and overwrite another, to show that writes take effect on the following lookup.

// File: rtl/sad_pkg.sv
package sad_pkg;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } sad_space_e;

   localparam int unsigned NUM_SPACES = 2;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sad_range_table.sv
module sad_range_table #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NODE_W  = 3,
   parameter int unsigned IDX_W   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic                            wr_valid,
   input  logic [ADDR_W-1:0]               wr_base,
   input  logic [ADDR_W-1:0]               wr_limit,
   input  logic [NODE_W-1:0]               wr_node,
   output logic [ENTRIES-1:0]              ent_valid,
   output logic [ENTRIES-1:0][ADDR_W-1:0]  ent_base,
   output logic [ENTRIES-1:0][ADDR_W-1:0]  ent_limit,
   output logic [ENTRIES-1:0][NODE_W-1:0]  ent_node
);

   if (ENTRIES < 1) begin : g_bad_entries
      $error("sad_range_table: ENTRIES must be at least 1");
   end
   if ((1 << IDX_W) < ENTRIES) begin : g_bad_idx
      $error("sad_range_table: IDX_W too narrow for ENTRIES");
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[i] <= 1'b0;
            ent_base[i]  <= '0;
            ent_limit[i] <= '0;
            ent_node[i]  <= '0;
         end else if (sel) begin
            ent_valid[i] <= wr_valid;
            ent_base[i]  <= wr_base;
            ent_limit[i] <= wr_limit;
            ent_node[i]  <= wr_node;
         end
      end

      // R9: a write to this slot is visible on the following cycle
      p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(i)) |=>
            (ent_valid[i] == $past(wr_valid) && ent_base[i] == $past(wr_base) &&
             ent_limit[i] == $past(wr_limit) && ent_node[i] == $past(wr_node)));
   end

endmodule

// File: rtl/sad_range_match.sv
module sad_range_match #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NODE_W  = 3
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [ENTRIES-1:0]              ent_valid,
   input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_base,
   input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_limit,
   input  logic [ENTRIES-1:0][NODE_W-1:0]  ent_node,
   output logic                            hit,
   output logic [NODE_W-1:0]               node,
   output logic [ADDR_W-1:0]               offset
);

   logic [ENTRIES-1:0] covers;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign covers[i] = ent_valid[i] &&
                         (addr >= ent_base[i]) && (addr <= ent_limit[i]);
   end

   // walk from the top so the lowest index is written last and wins
   always_comb begin
      hit    = 1'b0;
      node   = '0;
      offset = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (covers[i]) begin
            hit    = 1'b1;
            node   = ent_node[i];
            offset = addr - ent_base[i];
         end
      end
   end

endmodule

// File: rtl/src_addr_decoder.sv
module src_addr_decoder
   import sad_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NODE_W      = 3,
   parameter int unsigned MEM_ENTRIES = 4,
   parameter int unsigned IO_ENTRIES  = 4,
   localparam int unsigned MAX_ENTRIES = (MEM_ENTRIES > IO_ENTRIES) ? MEM_ENTRIES : IO_ENTRIES,
   localparam int unsigned IDX_W       = idx_width(MAX_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_io,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic               cfg_valid,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [ADDR_W-1:0]  cfg_limit,
   input  logic [NODE_W-1:0]  cfg_node,
   input  logic               req_valid,
   input  logic               req_io,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_miss,
   output logic [NODE_W-1:0]  rsp_node,
   output logic [ADDR_W-1:0]  rsp_offset
);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
      $error("src_addr_decoder: ADDR_W must be 1..64");
   end
   if (NODE_W < 1) begin : g_bad_node
      $error("src_addr_decoder: NODE_W must be at least 1");
   end
   if (MEM_ENTRIES < 1 || IO_ENTRIES < 1) begin : g_bad_depth
      $error("src_addr_decoder: each table needs at least one entry");
   end

   logic              sp_hit    [NUM_SPACES];
   logic [NODE_W-1:0] sp_node   [NUM_SPACES];
   logic [ADDR_W-1:0] sp_offset [NUM_SPACES];

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      localparam int unsigned N  = (s == int'(SPACE_IO)) ? IO_ENTRIES : MEM_ENTRIES;
      localparam int unsigned TW = idx_width(N);

      logic                       wr_en;
      logic [N-1:0]               t_valid;
      logic [N-1:0][ADDR_W-1:0]   t_base;
      logic [N-1:0][ADDR_W-1:0]   t_limit;
      logic [N-1:0][NODE_W-1:0]   t_node;

      // slots past this table's depth are dropped
      assign wr_en = cfg_we && (cfg_io == 1'(s)) && (32'(cfg_idx) < N);

      sad_range_table #(
         .ENTRIES(N), .ADDR_W(ADDR_W), .NODE_W(NODE_W), .IDX_W(TW)
      ) u_table (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .wr_idx    (TW'(cfg_idx)),
         .wr_valid  (cfg_valid),
         .wr_base   (cfg_base),
         .wr_limit  (cfg_limit),
         .wr_node   (cfg_node),
         .ent_valid (t_valid),
         .ent_base  (t_base),
         .ent_limit (t_limit),
         .ent_node  (t_node)
      );

      sad_range_match #(
         .ENTRIES(N), .ADDR_W(ADDR_W), .NODE_W(NODE_W)
      ) u_match (
         .addr      (req_addr),
         .ent_valid (t_valid),
         .ent_base  (t_base),
         .ent_limit (t_limit),
         .ent_node  (t_node),
         .hit       (sp_hit[s]),
         .node      (sp_node[s]),
         .offset    (sp_offset[s])
      );
   end

   logic              sel_hit;
   logic [NODE_W-1:0] sel_node;
   logic [ADDR_W-1:0] sel_offset;

   always_comb begin
      sel_hit    = sp_hit[req_io];
      sel_node   = sp_node[req_io];
      sel_offset = sp_offset[req_io];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_node   <= '0;
         rsp_offset <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_hit    <= req_valid && sel_hit;
         rsp_miss   <= req_valid && !sel_hit;
         rsp_node   <= (req_valid && sel_hit) ? sel_node   : '0;
         rsp_offset <= (req_valid && sel_hit) ? sel_offset : '0;
      end
   end

   // R7: reply follows the request by exactly one cycle
   p_reply_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

   // R6: every valid reply is either a hit or a miss, never both
   p_hit_miss_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit ^ rsp_miss));
   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_node == '0 && rsp_offset == '0));

   // R2: rebasing subtracts a base that is not above the address
   p_offset_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_offset <= $past(req_addr)));

endmodule

// File: tb/tb_src_addr_decoder.sv
module tb_src_addr_decoder;

   localparam int AW = 32;
   localparam int NW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_io = 1'b0, cfg_valid = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
   logic [NW-1:0] cfg_node = '0;
   logic          req_valid = 1'b0, req_io = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_hit, rsp_miss;
   logic [NW-1:0] rsp_node;
   logic [AW-1:0] rsp_offset;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   src_addr_decoder dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_io(cfg_io), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_node(cfg_node),
      .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_node(rsp_node), .rsp_offset(rsp_offset)
   );

   // {io, addr, hit, node, offset}
   localparam int NV = 15;
   localparam logic [68:0] VEC [NV] = '{
      {1'b0, 32'h0000_0000, 1'b1, 3'd2, 32'h0000_0000},
      {1'b0, 32'h1234_5678, 1'b1, 3'd2, 32'h1234_5678},
      {1'b0, 32'h7FFF_FFFF, 1'b1, 3'd2, 32'h7FFF_FFFF},
      {1'b0, 32'h8000_0000, 1'b1, 3'd3, 32'h0000_0000},
      {1'b0, 32'hDFFF_FFFF, 1'b1, 3'd3, 32'h5FFF_FFFF},
      {1'b0, 32'hD800_0000, 1'b1, 3'd3, 32'h5800_0000},
      {1'b0, 32'hE800_0000, 1'b1, 3'd7, 32'h1800_0000},
      {1'b0, 32'hEFFF_FFFF, 1'b1, 3'd7, 32'h1FFF_FFFF},
      {1'b0, 32'hF000_0000, 1'b0, 3'd0, 32'h0000_0000},
      {1'b1, 32'h0000_0000, 1'b1, 3'd5, 32'h0000_0000},
      {1'b1, 32'h0000_0FFF, 1'b1, 3'd5, 32'h0000_0FFF},
      {1'b1, 32'h0000_1000, 1'b1, 3'd6, 32'h0000_0000},
      {1'b1, 32'h0000_FFFF, 1'b1, 3'd6, 32'h0000_EFFF},
      {1'b1, 32'h0001_0000, 1'b0, 3'd0, 32'h0000_0000},
      {1'b1, 32'h8000_0000, 1'b0, 3'd0, 32'h0000_0000}
   };

   task automatic check(input string req, input logic v, input logic h, input logic m,
                        input logic [NW-1:0] n, input logic [AW-1:0] o);
      checks++;
      if (rsp_valid !== v || rsp_hit !== h || rsp_miss !== m ||
          rsp_node !== n || rsp_offset !== o) begin
         errors++;
         $display("FAIL %s: got v=%0b h=%0b m=%0b node=%0d off=%h, expected v=%0b h=%0b m=%0b node=%0d off=%h",
                  req, rsp_valid, rsp_hit, rsp_miss, rsp_node, rsp_offset, v, h, m, n, o);
      end
   endtask

   task automatic wr(input logic io, input int idx, input logic vld,
                     input logic [AW-1:0] b, input logic [AW-1:0] l, input logic [NW-1:0] n);
      @(negedge clk);
      cfg_we = 1'b1; cfg_io = io; cfg_idx = 2'(idx); cfg_valid = vld;
      cfg_base = b; cfg_limit = l; cfg_node = n;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive at negedge, sample just after the next rising edge
   task automatic look(input logic io, input logic [AW-1:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_io = io; req_addr = a;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 check("R8 reset outputs", 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
      rst_n = 1'b1;
      look(1'b0, 32'h0000_0000);
      check("R8 empty table misses", 1'b1, 1'b0, 1'b1, 3'd0, 32'h0);
      look(1'b1, 32'h0000_0000);
      check("R8 empty io table misses", 1'b1, 1'b0, 1'b1, 3'd0, 32'h0);
      @(negedge clk) req_valid = 1'b0;

      wr(1'b0, 0, 1'b1, 32'h0000_0000, 32'h7FFF_FFFF, 3'd2);
      wr(1'b0, 1, 1'b1, 32'h8000_0000, 32'hDFFF_FFFF, 3'd3);
      wr(1'b0, 3, 1'b1, 32'hD000_0000, 32'hEFFF_FFFF, 3'd7);
      wr(1'b1, 0, 1'b1, 32'h0000_0000, 32'h0000_0FFF, 3'd5);
      wr(1'b1, 1, 1'b1, 32'h0000_1000, 32'h0000_FFFF, 3'd6);

      // R1 R2 R3 R4 R5 R6 table walk
      for (int i = 0; i < NV; i++) begin
         look(VEC[i][68], VEC[i][67:36]);
         check("R1/R2/R3/R4/R5/R6 vector", 1'b1, VEC[i][35], !VEC[i][35],
               VEC[i][34:32], VEC[i][31:0]);
      end

      // R7: idle cycle gives a quiet reply
      @(negedge clk) req_valid = 1'b0;
      @(posedge clk); #1;
      check("R7 idle", 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);

      // R7: reply not visible before the edge
      @(negedge clk);
      req_valid = 1'b1; req_io = 1'b0; req_addr = 32'h8000_0010;
      #5 check("R7 no early reply", 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
      @(posedge clk); #1;
      check("R7 reply after one edge", 1'b1, 1'b1, 1'b0, 3'd3, 32'h0000_0010);
      @(negedge clk) req_valid = 1'b0;

      // R9: invalidate an I/O entry, next lookup misses
      wr(1'b1, 0, 1'b0, 32'h0000_0000, 32'h0000_0FFF, 3'd5);
      look(1'b1, 32'h0000_0800);
      check("R9 invalidated entry misses", 1'b1, 1'b0, 1'b1, 3'd0, 32'h0);
      look(1'b1, 32'h0000_2000);
      check("R9 other entry intact", 1'b1, 1'b1, 1'b0, 3'd6, 32'h0000_1000);

      // R9 R5: overwrite entry 1 narrow so overlap entry 3 now supplies node
      wr(1'b0, 1, 1'b1, 32'h8000_0000, 32'hCFFF_FFFF, 3'd4);
      look(1'b0, 32'hD800_0000);
      check("R9/R5 rewrite exposes entry 3", 1'b1, 1'b1, 1'b0, 3'd7, 32'h0800_0000);
      look(1'b0, 32'h9000_0000);
      check("R9 new node", 1'b1, 1'b1, 1'b0, 3'd4, 32'h1000_0000);

      // R4: memory-only address in I/O space
      look(1'b1, 32'h4000_0000);
      check("R4 memory window ignored for io", 1'b1, 1'b0, 1'b1, 3'd0, 32'h0);
      @(negedge clk) req_valid = 1'b0;

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule